// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a general-purpose parallel I/O port of up to 32 pins. A simple 32-bit register bus reaches four word registers: pin data, pin direction, interrupt enable mask and edge capture. Every pin has an output latch, an output-enable line for an external tristate driver, and an input that passes through a two-flop synchronizer before any logic uses it.

How the interrupt is raised is fixed when the block is built, by the `TRIG_MODE` parameter. In the three edge modes (rising, falling, either) each detected edge sets a sticky capture bit. Software clears the bit by writing a one to it. The single interrupt line is high while any captured bit is also enabled in the mask. In level-high mode the capture register stays empty, and the interrupt follows the enabled synchronized pin levels directly.

The bus selects a register with a two-bit word index, so byte offsets 0x0, 0x4, 0x8 and 0xC become indices 0 to 3. A write takes effect at the clock edge that accepts it. Read data appears on `busRdData` one clock after `busRdEn`.

Top module: `pio_irq_port`

## Requirements
- R1: Word index 0 selects pin data, 1 selects direction, 2 selects interrupt mask and 3 selects edge capture. A write is applied at the accepting clock edge. Read data is valid on the clock after the read request and holds until the next read.
- R2: Register bits at positions at or above `PIN_COUNT` read as zero, and writes to them are ignored.
- R3: A direction bit of 1 drives that pin's `pinOe` high (output), and 0 makes it an input. `pinOe` takes the written direction value one clock after the write.
- R4: A data read returns the output latch for output pins and the synchronized pin level for input pins. A data write updates the latch of every pin, including pins that are currently inputs, and `pinOut` always shows the latch.
- R5: In edge modes a capture bit is set by the selected edge of the synchronized input, found by comparing it with its value one clock earlier. The capture bit is set on the third clock edge after the pin changes. Edges of the other polarity are ignored in the rising and falling modes.
- R6: Writing to the capture register clears exactly the bits that are 1 in the written word. Captured bits are never cleared any other way.
- R7: If a new edge arrives in the same cycle as a clear of that bit, the capture bit remains set.
- R8: In edge modes `irqOut` is a register. It is high one clock after the bitwise AND of capture and mask becomes nonzero, and low one clock after it becomes zero. Bits that are masked off stay captured but do not raise the interrupt.
- R9: In level-high mode `irqOut` is high one clock after any synchronized pin that is enabled in the mask is high, and low once none is. The capture register always reads zero in this mode.
- R10: An active-low synchronous reset clears every register, the output latches, the synchronizer history, `busRdData` and `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busWordSel | input | 2 | Register word index (byte offset / 4) |
| busWrEn | input | 1 | Write request, accepted in one cycle |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read request |
| busRdData | output | 32 | Read data, one clock after the request |
| pinIn | input | PIN_COUNT | Asynchronous pin inputs |
| pinOut | output | PIN_COUNT | Output latch values |
| pinOe | output | PIN_COUNT | Per-pin output enable (1 = drive) |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The assertions check four things on every cycle. First, `irqOut` tracks the masked capture word one clock later in the edge modes. Second, captured bits only fall on a capture write. Third, read data never carries bits above the pin count. Fourth, the output enables take the value of a direction write. Beyond those, the capture register stays empty in level mode, and reset clears the enables and the interrupt.

Only the bench's scenarios show the rest. That covers the synchronizer latency and edge polarity per mode, and the mixed input/output data read. It also covers the partial clear, and the race in which a new edge lands in the same cycle as its clear.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int BUS_W = 32;

  // trigger selections
  localparam int TRIG_RISE  = 0;
  localparam int TRIG_FALL  = 1;
  localparam int TRIG_BOTH  = 2;
  localparam int TRIG_LEVEL = 3;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CAP  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrMask;
    logic    wrCap;
    logic    rdEn;
    regSel_e rdSel;
  } pioStrobe_t;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [1:0] busWordSel,
  output pioStrobe_t strobe
);

  regSel_e sel;
  assign sel = regSel_e'(busWordSel);

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = busRdEn;
    strobe.rdSel  = sel;
    strobe.wrData = busWrEn && (sel == SEL_DATA);
    strobe.wrDir  = busWrEn && (sel == SEL_DIR);
    strobe.wrMask = busWrEn && (sel == SEL_MASK);
    strobe.wrCap  = busWrEn && (sel == SEL_CAP);
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int TRIG_MODE = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pioStrobe_t           strobe,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] pinSync,
  output logic [BUS_W-1:0]     rdData,
  output logic [PIN_COUNT-1:0] outLatch,
  output logic [PIN_COUNT-1:0] dirReg,
  output logic [PIN_COUNT-1:0] maskReg,
  output logic [PIN_COUNT-1:0] capReg,
  output logic                 irqOut
);

  logic [PIN_COUNT-1:0] wrPins;
  logic [PIN_COUNT-1:0] prevSync;
  logic [PIN_COUNT-1:0] edgeHit;
  logic [PIN_COUNT-1:0] irqSrc;
  logic [PIN_COUNT-1:0] dataView;
  logic [BUS_W-1:0]     rdNext;

  assign wrPins = wrData[PIN_COUNT-1:0];

  // edge detector variant picked by the trigger parameter
  if (TRIG_MODE == TRIG_RISE) begin : g_rise
    assign edgeHit = pinSync & ~prevSync;
    assign irqSrc  = capReg;
  end else if (TRIG_MODE == TRIG_FALL) begin : g_fall
    assign edgeHit = ~pinSync & prevSync;
    assign irqSrc  = capReg;
  end else if (TRIG_MODE == TRIG_BOTH) begin : g_both
    assign edgeHit = pinSync ^ prevSync;
    assign irqSrc  = capReg;
  end else begin : g_level
    assign edgeHit = '0;
    assign irqSrc  = pinSync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outLatch <= '0;
      dirReg   <= '0;
      maskReg  <= '0;
      capReg   <= '0;
      prevSync <= '0;
      irqOut   <= 1'b0;
    end else begin
      prevSync <= pinSync;
      if (strobe.wrData) outLatch <= wrPins;
      if (strobe.wrDir)  dirReg   <= wrPins;
      if (strobe.wrMask) maskReg  <= wrPins;
      // new edges win over a simultaneous clear
      capReg <= (capReg & ~(strobe.wrCap ? wrPins : '0)) | edgeHit;
      irqOut <= |(irqSrc & maskReg);
    end
  end

  assign dataView = (dirReg & outLatch) | (~dirReg & pinSync);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: rdNext = BUS_W'(dataView);
      SEL_DIR:  rdNext = BUS_W'(dirReg);
      SEL_MASK: rdNext = BUS_W'(maskReg);
      default:  rdNext = BUS_W'(capReg);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int TRIG_MODE = TRIG_RISE,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           busWordSel,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  input  logic                 busRdEn,
  output logic [31:0]          busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  pioStrobe_t           strobe;
  logic [PIN_COUNT-1:0] pinSync;
  logic [PIN_COUNT-1:0] outLatch;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] maskReg;
  logic [PIN_COUNT-1:0] capReg;

  pio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  pio_ctrl u_ctrl (
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busWordSel (busWordSel),
    .strobe     (strobe)
  );

  pio_datapath #(.PIN_COUNT(PIN_COUNT), .TRIG_MODE(TRIG_MODE)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrData   (busWrData),
    .pinSync  (pinSync),
    .rdData   (busRdData),
    .outLatch (outLatch),
    .dirReg   (dirReg),
    .maskReg  (maskReg),
    .capReg   (capReg),
    .irqOut   (irqOut)
  );

  assign pinOut = outLatch;
  assign pinOe  = dirReg;

endmodule

// File: rtl/pio_irq_port_chk.sv
module pio_irq_port_chk
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int TRIG_MODE = TRIG_RISE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           busWordSel,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic                 busRdEn,
  input logic [31:0]          busRdData,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 irqOut,
  input logic [PIN_COUNT-1:0] capReg,
  input logic [PIN_COUNT-1:0] maskReg
);

  localparam logic [63:0] VALID64 = (64'h1 << PIN_COUNT) - 64'h1;
  localparam logic [31:0] VALID   = VALID64[31:0];

  logic capWrite;
  logic dirWrite;
  assign capWrite = busWrEn && (busWordSel == 2'd3);
  assign dirWrite = busWrEn && (busWordSel == 2'd1);

  // R2: read data is clean above the pin count
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn |=> ((busRdData & ~VALID) == 32'h0));

  // R3: enables follow a direction write
  p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dirWrite |=> (32'(pinOe) == ($past(busWrData) & VALID)));

  // R6: captured bits only fall on a capture write
  p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capWrite |=> ((capReg & $past(capReg)) == $past(capReg)));

  // R10: reset clears enables and interrupt
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (pinOe == '0 && !irqOut));

  if (TRIG_MODE == TRIG_LEVEL) begin : g_lvl
    // R9: capture unused in level mode
    p_level_nocap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      capReg == '0);
  end else begin : g_edge
    // R8: interrupt follows masked capture one clock later
    p_irq_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (capReg & maskReg) != '0 |=> irqOut);
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (capReg & maskReg) == '0 |=> !irqOut);
  end

endmodule

bind pio_irq_port pio_irq_port_chk #(
  .PIN_COUNT (PIN_COUNT),
  .TRIG_MODE (TRIG_MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busWordSel (busWordSel),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdEn    (busRdEn),
  .busRdData  (busRdData),
  .pinOe      (pinOe),
  .irqOut     (irqOut),
  .capReg     (capReg),
  .maskReg    (maskReg)
);

// File: tb/sim_pio_irq_port.sv
`timescale 1ns/1ps
module sim_pio_irq_port;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  busWordSel = '0;
  logic [2:0]  wrEnV = '0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [19:0] pin0 = '0;
  logic [7:0]  pin1 = '0;
  logic [11:0] pin2 = '0;
  logic [31:0] rd0, rd1, rd2;
  logic [19:0] po0, oe0;
  logic [7:0]  po1, oe1;
  logic [11:0] po2, oe2;
  logic        irq0, irq1, irq2;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // u0: 20 pins, either edge; u1: 8 pins, level high; u2: 12 pins, falling
  pio_irq_port #(.PIN_COUNT(20), .TRIG_MODE(TRIG_BOTH)) u0 (
    .clk(clk), .rst_n(rst_n), .busWordSel(busWordSel), .busWrEn(wrEnV[0]),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rd0),
    .pinIn(pin0), .pinOut(po0), .pinOe(oe0), .irqOut(irq0));
  pio_irq_port #(.PIN_COUNT(8), .TRIG_MODE(TRIG_LEVEL)) u1 (
    .clk(clk), .rst_n(rst_n), .busWordSel(busWordSel), .busWrEn(wrEnV[1]),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rd1),
    .pinIn(pin1), .pinOut(po1), .pinOe(oe1), .irqOut(irq1));
  pio_irq_port #(.PIN_COUNT(12), .TRIG_MODE(TRIG_FALL)) u2 (
    .clk(clk), .rst_n(rst_n), .busWordSel(busWordSel), .busWrEn(wrEnV[2]),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rd2),
    .pinIn(pin2), .pinOut(po2), .pinOe(oe2), .irqOut(irq2));

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic [7:0]  reqNo;
  } vec_t;

  // write to u0 then read the same word back (pins held low)
  localparam vec_t VECS [8] = '{
    '{2'd1, 32'hFFFFFFFF, 32'h000FFFFF, 8'd2},  // R2
    '{2'd1, 32'h12345678, 32'h00045678, 8'd2},  // R2
    '{2'd2, 32'hA5A5A5A5, 32'h0005A5A5, 8'd2},  // R2
    '{2'd2, 32'h00000000, 32'h00000000, 8'd1},  // R1
    '{2'd1, 32'hFFFFFFFF, 32'h000FFFFF, 8'd3},  // R3
    '{2'd0, 32'hCAFEF00D, 32'h000EF00D, 8'd4},  // R4 outputs read latch
    '{2'd1, 32'h00000000, 32'h00000000, 8'd3},  // R3
    '{2'd0, 32'h12345678, 32'h00000000, 8'd4}   // R4 inputs read pins
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input int which, input logic [1:0] sel, input logic [31:0] d);
    busWordSel = sel;
    busWrData  = d;
    wrEnV      = 3'b001 << which;
    @(posedge clk);
    @(negedge clk);
    wrEnV      = '0;
  endtask

  task automatic busRead(input logic [1:0] sel);
    busWordSel = sel;
    busRdEn    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRdEn    = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(3);
    // R10: reset state at the ports
    check("R10 oe", 32'(oe0), 32'h0);
    check("R10 pinOut", 32'(po0), 32'h0);
    check("R10 irq", 32'(irq0), 32'h0);
    rst_n = 1'b1;
    tick(1);
    for (int s = 0; s < 4; s++) begin
      busRead(2'(s));
      check("R10 register zero", rd0, 32'h0);
    end

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      busWrite(0, VECS[i].sel, VECS[i].wdata);
      busRead(VECS[i].sel);
      nChecks++;
      if (rd0 !== VECS[i].expRd) begin
        nErrors++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[i].reqNo, i, rd0, VECS[i].expRd);
      end
    end
    // R4: latch updated while pins were inputs; R3 enables low
    check("R4 latch while input", 32'(po0), 32'h45678);
    check("R3 oe all input", 32'(oe0), 32'h0);

    // R4: synchronized input read, then mixed directions
    pin0 = 20'hABCDE;
    tick(2);
    busRead(2'd0);
    check("R4 input read", rd0, 32'h000ABCDE);
    busWrite(0, 2'd1, 32'h000000FF);
    check("R3 oe after write", 32'(oe0), 32'h000FF);
    busRead(2'd0);
    check("R4 mixed read", rd0, 32'h000ABC78);
    busWrite(0, 2'd1, 32'h0);
    busWrite(0, 2'd3, 32'hFFFFFFFF);
    busRead(2'd3);
    check("R6 clear all", rd0, 32'h0);

    // R5: either-edge capture on u0
    busWrite(0, 2'd2, 32'h1);
    pin0 = 20'hABCDF;               // rising on bit 0
    tick(3);
    busRead(2'd3);
    check("R5 rising captured", rd0, 32'h1);
    check("R8 irq raised", 32'(irq0), 32'h1);
    pin0 = 20'hABCCF;               // falling on bit 4
    tick(3);
    busRead(2'd3);
    check("R5 falling captured", rd0, 32'h11);
    busWrite(0, 2'd3, 32'h1);
    busRead(2'd3);
    check("R6 partial clear", rd0, 32'h10);
    check("R8 masked bit silent", 32'(irq0), 32'h0);
    busWrite(0, 2'd2, 32'h10);
    tick(1);
    check("R8 irq after unmask", 32'(irq0), 32'h1);

    // R7: new edge in the same cycle as the clear of that bit
    pin0 = 20'hABCDF;               // rising on bit 4
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busWrite(0, 2'd3, 32'h10);
    busRead(2'd3);
    check("R7 edge beats clear", rd0, 32'h10);
    busWrite(0, 2'd3, 32'h10);
    busRead(2'd3);
    check("R6 clear after race", rd0, 32'h0);
    tick(1);
    check("R8 irq dropped", 32'(irq0), 32'h0);

    // R5: falling-only mode ignores rising edges (u2)
    busWrite(2, 2'd2, 32'hFFFFFFFF);
    busRead(2'd2);
    check("R2 mask u2", rd2, 32'h00000FFF);
    pin2 = 12'hFFF;
    tick(3);
    busRead(2'd3);
    check("R5 rising ignored", rd2, 32'h0);
    check("R5 no irq on rising", 32'(irq2), 32'h0);
    pin2 = 12'h0F0;
    tick(3);
    busRead(2'd3);
    check("R5 falling captured u2", rd2, 32'h00000F0F);
    check("R8 irq u2", 32'(irq2), 32'h1);

    // R9: level-high mode (u1)
    busWrite(1, 2'd2, 32'hFF);
    check("R9 irq idle", 32'(irq1), 32'h0);
    pin1 = 8'h04;
    tick(3);
    check("R9 irq level high", 32'(irq1), 32'h1);
    busRead(2'd3);
    check("R9 capture empty", rd1, 32'h0);
    busWrite(1, 2'd2, 32'h03);
    tick(1);
    check("R9 masked level", 32'(irq1), 32'h0);
    pin1 = 8'h01;
    tick(3);
    check("R9 unmasked level", 32'(irq1), 32'h1);
    pin1 = 8'h00;
    tick(3);
    check("R9 level released", 32'(irq1), 32'h0);

    // R10: reset in mid run
    busWrite(0, 2'd1, 32'hFFFFF);
    busWrite(0, 2'd2, 32'h3);
    rst_n = 1'b0;
    tick(1);
    check("R10 oe cleared", 32'(oe0), 32'h0);
    check("R10 latch cleared", 32'(po0), 32'h0);
    rst_n = 1'b1;
    busRead(2'd2);
    check("R10 mask cleared", rd0, 32'h0);

    finishRun();
  end

endmodule